// File: doc/BRIEF.md
# Adaptive Diagnosis Vector Selector

This block chooses, one step at a time, which input vector to apply next to a combinational unit under diagnosis. A precomputed diagnosis table is written in through a simple write port. Each row of the table is one candidate input vector. Each column is one output value that could be observed. Each cell is a bitmask of the circuit states that could explain that input/output pair. One bit stands for the fault-free state and one bit for each suspect component or group. An impossible pair is stored as an all-zero cell.

After `start`, the engine keeps a mask of surviving candidate states, seeded from the evidence inputs. It walks the unused rows one per clock and scores each row against the surviving mask. It then presents the best row. The caller applies that vector to the circuit, observes the output, and returns the column index. The engine intersects the surviving mask with the chosen cell and repeats. It stops when at most one candidate remains, or when no row can still tell candidates apart. Two scoring rules are available. The worst-case rule minimises the largest surviving cell in a row. The overlap rule minimises the largest pairwise overlap between two cells of a row.

The controller is a five-state machine:
- IDLE waits for the table load and the first `start`.
- CHECK tests whether the session is finished.
- SCORE scans the rows.
- ISSUE presents a row and waits for the observed column.
- DONE holds the result until the next `start`.

Its transitions are:
- IDLE→CHECK on `start`.
- CHECK→DONE when at most one candidate is left or every row is used; otherwise CHECK→SCORE.
- SCORE→ISSUE after the last row when some row qualified; otherwise SCORE→DONE.
- ISSUE→CHECK on `obs_valid`.
- DONE→CHECK on `start`.

Top module: `diag_vector_selector`

## Requirements
- R1: After reset `sel_valid`, `done` and `ambiguous` are 0 and `cand_mask` is all zero.
- R2: A cycle with `wr_en` high stores `wr_mask` into the cell at row `wr_row`, column `wr_col`. Every later score uses that content.
- R3: With `mode_overlap`=0 a row scores the largest popcount over its columns of (cell AND candidate mask). The lowest-scoring qualifying row is presented, and `sel_score` carries its score.
- R4: With `mode_overlap`=1 a row scores the largest popcount of (cell j AND cell k AND candidate mask) over all column pairs j<k. The lowest-scoring qualifying row is presented.
- R5: When several qualifying rows share the lowest score, the one with the smallest row index is presented.
- R6: A row qualifies only if it has not been presented in this session, and at least one masked cell is non-zero and differs from the candidate mask. It must also not be masked-equal, column by column, to any row with a smaller index.
- R7: `sel_valid` rises exactly ROWS+1 clock edges after the edge that accepts `start` or `obs_valid`, unless the session ends sooner. `sel_row` and `cand_mask` then hold steady until `obs_valid` is accepted.
- R8: When `obs_valid` is sampled while `sel_valid` is high, the candidate mask becomes itself AND the cell at (`sel_row`, `obs_col`). The row is marked used and is never presented again in that session.
- R9: At an accepted `start`, the candidate mask is set to NOT `ev_good`. If `ev_fail` is non-zero, it is set to `ev_fail` AND NOT `ev_good` instead. The scoring mode is latched at the same edge.
- R10: `done` is raised one edge after acceptance when the candidate mask has at most one bit set or every row is used. It is raised ROWS+1 edges after acceptance when no row qualifies. `ambiguous` is high exactly while `done` is high with more than one candidate bit left.
- R11: `start` is ignored outside IDLE and DONE, and `obs_valid` is ignored unless `sel_valid` is high. Neither changes `cand_mask` or the presentation timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Table write strobe |
| wr_row | input | clog2(ROWS) | Row of the cell being written |
| wr_col | input | clog2(COLS) | Column of the cell being written |
| wr_mask | input | NSTATE | Candidate-state set for the cell |
| start | input | 1 | Begin a diagnosis session |
| mode_overlap | input | 1 | 0: worst-case cell rule, 1: pairwise overlap rule |
| ev_good | input | NSTATE | States known to be good, removed from the candidates |
| ev_fail | input | NSTATE | States known to be failed; if non-zero, the candidates are limited to them |
| obs_valid | input | 1 | Observed output column is valid |
| obs_col | input | clog2(COLS) | Observed output column |
| sel_valid | output | 1 | A chosen row is presented |
| sel_row | output | clog2(ROWS) | Index of the chosen row |
| sel_score | output | clog2(NSTATE+1) | Score of the chosen row |
| cand_mask | output | NSTATE | Surviving candidate states |
| done | output | 1 | Session finished |
| ambiguous | output | 1 | Finished with more than one candidate left |

## Verification
A selection is due ROWS+1 edges after the edge that accepts `start` or an observation. A finish caused by a small candidate mask or by exhausted rows is due one edge after acceptance, and a finish because nothing qualifies is due ROWS+1 edges after. The bench first works out which of these applies from its own model of the session. It then samples on every falling edge from acceptance onward, requiring the outputs to stay quiet until the due edge and to match exactly on it. Stray `start` and observation pulses are injected during a scan to confirm that the timing and the mask do not move.

// File: rtl/diag_sel_pkg.sv
`timescale 1ns/1ps
package diag_sel_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CHECK = 3'd1,
        ST_SCORE = 3'd2,
        ST_ISSUE = 3'd3,
        ST_DONE  = 3'd4
    } sel_state_e;

endpackage

// File: rtl/diag_matrix_store.sv
`timescale 1ns/1ps
module diag_matrix_store #(
    parameter int ROWS   = 8,
    parameter int COLS   = 4,
    parameter int NSTATE = 16,
    parameter int RW     = 3,
    parameter int CW     = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [RW-1:0]                 wr_row,
    input  logic [CW-1:0]                 wr_col,
    input  logic [NSTATE-1:0]             wr_mask,
    output logic [ROWS*COLS*NSTATE-1:0]   mat_flat
);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            logic [NSTATE-1:0] cell_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cell_q <= '0;
                end else if (wr_en && (wr_row == RW'(r)) && (wr_col == CW'(c))) begin
                    cell_q <= wr_mask;
                end
            end

            assign mat_flat[(r*COLS + c)*NSTATE +: NSTATE] = cell_q;
        end
    end

endmodule

// File: rtl/diag_row_scorer.sv
`timescale 1ns/1ps
module diag_row_scorer #(
    parameter int COLS   = 4,
    parameter int NSTATE = 16,
    parameter int SW     = 5
) (
    input  logic [COLS*NSTATE-1:0] row_cells,
    input  logic [NSTATE-1:0]      cand,
    input  logic                   mode_overlap,
    output logic [SW-1:0]          score,
    output logic                   informative
);

    logic [NSTATE-1:0] msk [COLS];

    for (genvar c = 0; c < COLS; c++) begin : g_mask
        assign msk[c] = row_cells[c*NSTATE +: NSTATE] & cand;
    end

    always_comb begin : calc
        logic [SW-1:0] worst;
        logic [SW-1:0] ovl;
        logic [SW-1:0] pc;
        worst       = '0;
        ovl         = '0;
        informative = 1'b0;
        for (int j = 0; j < COLS; j++) begin
            pc = SW'($countones(msk[j]));
            if (pc > worst) begin
                worst = pc;
            end
            if ((msk[j] != '0) && (msk[j] != cand)) begin
                informative = 1'b1;
            end
            for (int k = j + 1; k < COLS; k++) begin
                pc = SW'($countones(msk[j] & msk[k]));
                if (pc > ovl) begin
                    ovl = pc;
                end
            end
        end
        score = mode_overlap ? ovl : worst;
    end

endmodule

// File: rtl/diag_dup_detect.sv
`timescale 1ns/1ps
module diag_dup_detect #(
    parameter int ROWS   = 8,
    parameter int COLS   = 4,
    parameter int NSTATE = 16,
    parameter int RW     = 3
) (
    input  logic [ROWS*COLS*NSTATE-1:0] mat_flat,
    input  logic [COLS*NSTATE-1:0]      cur_row,
    input  logic [NSTATE-1:0]           cand,
    input  logic [RW-1:0]               idx,
    output logic                        dup
);

    always_comb begin : cmp
        logic same;
        dup = 1'b0;
        for (int j = 0; j < ROWS; j++) begin
            same = 1'b1;
            for (int c = 0; c < COLS; c++) begin
                if (((cur_row[c*NSTATE +: NSTATE] ^
                      mat_flat[(j*COLS + c)*NSTATE +: NSTATE]) & cand) != '0) begin
                    same = 1'b0;
                end
            end
            if (same && (j < int'(idx))) begin
                dup = 1'b1;
            end
        end
    end

endmodule

// File: rtl/diag_vector_selector.sv
`timescale 1ns/1ps
module diag_vector_selector #(
    parameter int ROWS   = 8,
    parameter int COLS   = 4,
    parameter int NSTATE = 16,
    localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CW    = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int SW    = $clog2(NSTATE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [RW-1:0]     wr_row,
    input  logic [CW-1:0]     wr_col,
    input  logic [NSTATE-1:0] wr_mask,
    input  logic              start,
    input  logic              mode_overlap,
    input  logic [NSTATE-1:0] ev_good,
    input  logic [NSTATE-1:0] ev_fail,
    input  logic              obs_valid,
    input  logic [CW-1:0]     obs_col,
    output logic              sel_valid,
    output logic [RW-1:0]     sel_row,
    output logic [SW-1:0]     sel_score,
    output logic [NSTATE-1:0] cand_mask,
    output logic              done,
    output logic              ambiguous
);

    localparam int RB = COLS * NSTATE;
    localparam int MB = ROWS * RB;

    diag_sel_pkg::sel_state_e state_q, state_d;

    logic [RW-1:0]     idx_q;
    logic [RW-1:0]     best_q;
    logic [SW-1:0]     best_score_q;
    logic              found_q;
    logic [ROWS-1:0]   used_q;
    logic [NSTATE-1:0] cand_q;
    logic              mode_q;

    logic [MB-1:0]     mat_flat;
    logic [RB-1:0]     cur_row;
    logic [NSTATE-1:0] obs_cell;
    logic [NSTATE-1:0] start_cand;
    logic [SW-1:0]     row_score;
    logic              row_inf;
    logic              row_dup;
    logic              row_ok;
    logic              take;
    logic              last_row;
    logic              any_found;
    logic              cand_small;
    logic              accept_start;

    diag_matrix_store #(
        .ROWS(ROWS), .COLS(COLS), .NSTATE(NSTATE), .RW(RW), .CW(CW)
    ) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_row   (wr_row),
        .wr_col   (wr_col),
        .wr_mask  (wr_mask),
        .mat_flat (mat_flat)
    );

    assign cur_row  = mat_flat[int'(idx_q)*RB +: RB];
    assign obs_cell = mat_flat[(int'(best_q)*COLS + int'(obs_col))*NSTATE +: NSTATE];

    diag_row_scorer #(
        .COLS(COLS), .NSTATE(NSTATE), .SW(SW)
    ) scorer_i (
        .row_cells    (cur_row),
        .cand         (cand_q),
        .mode_overlap (mode_q),
        .score        (row_score),
        .informative  (row_inf)
    );

    diag_dup_detect #(
        .ROWS(ROWS), .COLS(COLS), .NSTATE(NSTATE), .RW(RW)
    ) dup_i (
        .mat_flat (mat_flat),
        .cur_row  (cur_row),
        .cand     (cand_q),
        .idx      (idx_q),
        .dup      (row_dup)
    );

    assign start_cand   = (ev_fail != '0) ? (ev_fail & ~ev_good) : ~ev_good;
    assign row_ok       = !used_q[idx_q] && row_inf && !row_dup;
    assign take         = row_ok && (!found_q || (row_score < best_score_q));
    assign last_row     = (idx_q == RW'(ROWS - 1));
    assign any_found    = found_q || row_ok;
    assign cand_small   = ($countones(cand_q) <= 1);
    assign accept_start = start && ((state_q == diag_sel_pkg::ST_IDLE) ||
                                    (state_q == diag_sel_pkg::ST_DONE));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= diag_sel_pkg::ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            diag_sel_pkg::ST_IDLE: begin
                if (start) state_d = diag_sel_pkg::ST_CHECK;
            end
            diag_sel_pkg::ST_CHECK: begin
                if (cand_small || (&used_q)) state_d = diag_sel_pkg::ST_DONE;
                else                         state_d = diag_sel_pkg::ST_SCORE;
            end
            diag_sel_pkg::ST_SCORE: begin
                if (last_row) begin
                    state_d = any_found ? diag_sel_pkg::ST_ISSUE : diag_sel_pkg::ST_DONE;
                end
            end
            diag_sel_pkg::ST_ISSUE: begin
                if (obs_valid) state_d = diag_sel_pkg::ST_CHECK;
            end
            diag_sel_pkg::ST_DONE: begin
                if (start) state_d = diag_sel_pkg::ST_CHECK;
            end
            default: state_d = diag_sel_pkg::ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q        <= '0;
            best_q       <= '0;
            best_score_q <= '0;
            found_q      <= 1'b0;
            used_q       <= '0;
            cand_q       <= '0;
            mode_q       <= 1'b0;
        end else begin
            if (accept_start) begin
                cand_q <= start_cand;
                used_q <= '0;
                mode_q <= mode_overlap;
            end
            case (state_q)
                diag_sel_pkg::ST_CHECK: begin
                    idx_q   <= '0;
                    found_q <= 1'b0;
                end
                diag_sel_pkg::ST_SCORE: begin
                    if (take) begin
                        best_q       <= idx_q;
                        best_score_q <= row_score;
                        found_q      <= 1'b1;
                    end
                    if (!last_row) idx_q <= idx_q + 1'b1;
                end
                diag_sel_pkg::ST_ISSUE: begin
                    if (obs_valid) begin
                        cand_q         <= cand_q & obs_cell;
                        used_q[best_q] <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        sel_valid = (state_q == diag_sel_pkg::ST_ISSUE);
        sel_row   = best_q;
        sel_score = best_score_q;
        cand_mask = cand_q;
        done      = (state_q == diag_sel_pkg::ST_DONE);
        ambiguous = done && ($countones(cand_q) > 1);
    end

endmodule

// File: rtl/diag_vector_selector_chk.sv
`timescale 1ns/1ps
module diag_vector_selector_chk #(
    parameter int ROWS   = 8,
    parameter int COLS   = 4,
    parameter int NSTATE = 16,
    localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int SW    = $clog2(NSTATE + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              obs_valid,
    input logic              sel_valid,
    input logic [RW-1:0]     sel_row,
    input logic [SW-1:0]     sel_score,
    input logic [NSTATE-1:0] cand_mask,
    input logic              done,
    input logic              ambiguous
);

    a_r7_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && !obs_valid) |=> (sel_valid && $stable(sel_row) && $stable(cand_mask)));

    a_r7_row_range: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (int'(sel_row) < ROWS));

    a_r8_cand_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && obs_valid) |=> ((cand_mask & ~$past(cand_mask)) == '0));

    a_r3_score_bound: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (int'(sel_score) <= $countones(cand_mask)));

    a_r10_ambig_done: assert property (@(posedge clk) disable iff (!rst_n)
        ambiguous |-> (done && ($countones(cand_mask) > 1)));

    a_r10_done_resolved: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ambiguous) |-> ($countones(cand_mask) <= 1));

    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_valid, done}));

    a_r11_cand_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !(sel_valid && obs_valid)) |=> $stable(cand_mask));

endmodule

bind diag_vector_selector diag_vector_selector_chk #(
    .ROWS(ROWS), .COLS(COLS), .NSTATE(NSTATE)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .obs_valid (obs_valid),
    .sel_valid (sel_valid),
    .sel_row   (sel_row),
    .sel_score (sel_score),
    .cand_mask (cand_mask),
    .done      (done),
    .ambiguous (ambiguous)
);

// File: tb/diag_vector_selector_tb_top.sv
`timescale 1ns/1ps
module diag_vector_selector_tb_top;

    localparam int ROWS = 8, COLS = 4, NSTATE = 16;
    localparam int RW = 3, CW = 2, SW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [RW-1:0] wr_row = '0;
    logic [CW-1:0] wr_col = '0;
    logic [NSTATE-1:0] wr_mask = '0;
    logic start = 1'b0;
    logic mode_overlap = 1'b0;
    logic [NSTATE-1:0] ev_good = '0;
    logic [NSTATE-1:0] ev_fail = '0;
    logic obs_valid = 1'b0;
    logic [CW-1:0] obs_col = '0;
    logic sel_valid;
    logic [RW-1:0] sel_row;
    logic [SW-1:0] sel_score;
    logic [NSTATE-1:0] cand_mask;
    logic done;
    logic ambiguous;

    always #4 clk = ~clk;

    diag_vector_selector #(.ROWS(ROWS), .COLS(COLS), .NSTATE(NSTATE)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
        .wr_mask(wr_mask), .start(start), .mode_overlap(mode_overlap),
        .ev_good(ev_good), .ev_fail(ev_fail), .obs_valid(obs_valid), .obs_col(obs_col),
        .sel_valid(sel_valid), .sel_row(sel_row), .sel_score(sel_score),
        .cand_mask(cand_mask), .done(done), .ambiguous(ambiguous)
    );

    int checks = 0;
    int fails  = 0;

    // Behavioural session model
    logic [NSTATE-1:0] m_mat [ROWS][COLS];
    logic [NSTATE-1:0] m_cand;
    bit                m_used [ROWS];
    bit                m_mode;
    int                e_row;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic write_cell(input int r, input int c, input logic [NSTATE-1:0] v);
        wr_en   = 1'b1;
        wr_row  = RW'(r);
        wr_col  = CW'(c);
        wr_mask = v;
        m_mat[r][c] = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clear_table();
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                write_cell(r, c, '0);
    endtask

    function automatic void model_pick(output bit found, output int row, output int score);
        found = 0; row = 0; score = 0;
        for (int i = 0; i < ROWS; i++) begin
            logic [NSTATE-1:0] c [COLS];
            bit inf;
            bit dup;
            int s;
            inf = 0; dup = 0; s = 0;
            for (int j = 0; j < COLS; j++) begin
                c[j] = m_mat[i][j] & m_cand;
                if (c[j] != 0 && c[j] != m_cand) inf = 1;
            end
            for (int i2 = 0; i2 < i; i2++) begin
                bit eq;
                eq = 1;
                for (int j = 0; j < COLS; j++)
                    if ((m_mat[i2][j] & m_cand) != c[j]) eq = 0;
                if (eq) dup = 1;
            end
            if (m_mode == 0) begin
                for (int j = 0; j < COLS; j++)
                    if ($countones(c[j]) > s) s = $countones(c[j]);
            end else begin
                for (int j = 0; j < COLS; j++)
                    for (int k = j + 1; k < COLS; k++)
                        if ($countones(c[j] & c[k]) > s) s = $countones(c[j] & c[k]);
            end
            if (!m_used[i] && inf && !dup && (!found || s < score)) begin
                found = 1; row = i; score = s;
            end
        end
    endfunction

    // Called at the falling edge right after the accepting edge (R7, R10, R11)
    task automatic expect_outcome(input string req, input bit poke, output bit fin);
        bit found;
        int row, score, lat;
        bit all_used;
        all_used = 1;
        for (int i = 0; i < ROWS; i++) if (!m_used[i]) all_used = 0;
        model_pick(found, row, score);
        if ($countones(m_cand) <= 1 || all_used) begin
            lat = 1; fin = 1;
        end else begin
            lat = ROWS + 1; fin = !found;
        end
        for (int k = 0; k <= lat; k++) begin
            if (k > 0) @(negedge clk);
            if (k < lat) begin
                chk(!sel_valid && !done, req, "R7 quiet before due edge", {sel_valid, done}, 0);
                chk(cand_mask == m_cand, "R11", "cand during scan", cand_mask, m_cand);
                if (poke && k == 3) begin obs_valid = 1'b1; obs_col = '0; end
                if (poke && k == 4) begin obs_valid = 1'b0; start = 1'b1; end
                if (poke && k == 5) start = 1'b0;
            end else if (fin) begin
                chk(done && !sel_valid, req, "R10 done due", {sel_valid, done}, 1);
                chk(ambiguous == ($countones(m_cand) > 1), req, "R10 ambiguous",
                    ambiguous, ($countones(m_cand) > 1));
                chk(cand_mask == m_cand, req, "R8 final cand", cand_mask, m_cand);
            end else begin
                chk(sel_valid && !done, req, "R7 sel due", {sel_valid, done}, 2);
                chk(int'(sel_row) == row, req, "R3 R4 R6 row", sel_row, row);
                chk(int'(sel_score) == score, req, "R3 R4 score", sel_score, score);
                chk(cand_mask == m_cand, req, "R9 cand", cand_mask, m_cand);
                e_row = row;
            end
        end
    endtask

    task automatic begin_session(input bit mode, input logic [NSTATE-1:0] good,
                                 input logic [NSTATE-1:0] fail);
        m_mode = mode;
        m_cand = (fail != 0) ? (fail & ~good) : ~good;
        for (int i = 0; i < ROWS; i++) m_used[i] = 0;
        mode_overlap = mode; ev_good = good; ev_fail = fail; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic observe(input int col);
        obs_valid = 1'b1;
        obs_col   = CW'(col);
        m_cand    = m_cand & m_mat[e_row][col];
        m_used[e_row] = 1;
        @(negedge clk);
        obs_valid = 1'b0;
    endtask

    function automatic int pick_col(input bit high);
        int col;
        col = 0;
        for (int j = 0; j < COLS; j++) begin
            int jj;
            jj = high ? (COLS - 1 - j) : j;
            if ((m_mat[e_row][jj] & m_cand) != 0) begin
                col = jj;
                break;
            end
        end
        return col;
    endfunction

    task automatic run_rest(input string req, input bit high);
        bit fin;
        for (int s = 0; s < 20; s++) begin
            expect_outcome(req, 1'b0, fin);
            if (fin) break;
            observe(pick_col(high));
        end
    endtask

    initial begin : watchdog
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        bit fin;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(sel_valid == 0, "R1", "sel_valid", sel_valid, 0);
        chk(done == 0, "R1", "done", done, 0);
        chk(ambiguous == 0, "R1", "ambiguous", ambiguous, 0);
        chk(cand_mask == 0, "R1", "cand_mask", cand_mask, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table A, loaded through the write port (R2)
        clear_table();
        write_cell(0, 0, 16'h0003); write_cell(0, 1, 16'h003E);
        write_cell(1, 0, 16'h0007); write_cell(1, 1, 16'h0038);
        write_cell(2, 0, 16'h000F); write_cell(2, 1, 16'h0030);
        write_cell(3, 0, 16'h0007); write_cell(3, 1, 16'h0038);
        write_cell(4, 0, 16'h0009); write_cell(4, 1, 16'h0012); write_cell(4, 2, 16'h0024);
        write_cell(5, 0, 16'h003F);
        write_cell(6, 0, 16'h000C); write_cell(6, 1, 16'h0033);
        write_cell(7, 0, 16'h0001); write_cell(7, 1, 16'h0006);
        write_cell(7, 2, 16'h0018); write_cell(7, 3, 16'h0020);

        // Worst-case rule, good evidence narrows to 6 states (R3 R5 R9)
        begin_session(1'b0, ~16'h003F, 16'h0000);
        expect_outcome("R3", 1'b0, fin);
        chk(sel_row == 4, "R5", "tie to lowest row", sel_row, 4);
        chk(sel_score == 2, "R3", "worst-case score", sel_score, 2);
        chk(cand_mask == 16'h003F, "R9", "good evidence", cand_mask, 16'h003F);
        repeat (3) @(negedge clk);
        chk(sel_valid && sel_row == 4, "R7", "hold while waiting", sel_row, 4);
        observe(1);
        expect_outcome("R11", 1'b1, fin);
        chk(sel_row == 1, "R6", "masked duplicate skipped", sel_row, 1);
        observe(1);
        expect_outcome("R10", 1'b0, fin);
        chk(done && !ambiguous && cand_mask == 16'h0010, "R10", "located", cand_mask, 16'h0010);

        // Pairwise overlap rule from DONE (R4)
        begin_session(1'b1, ~16'h003F, 16'h0000);
        expect_outcome("R4", 1'b0, fin);
        chk(sel_row == 1 && sel_score == 0, "R4", "overlap pick", sel_row, 1);
        observe(0);
        run_rest("R4", 1'b1);

        // Duplicate of a used row leaves the session ambiguous (R6)
        clear_table();
        write_cell(0, 0, 16'h0003); write_cell(0, 1, 16'h0006);
        write_cell(1, 0, 16'h0003); write_cell(1, 1, 16'h0006);
        begin_session(1'b0, ~16'h0007, 16'h0000);
        expect_outcome("R6", 1'b0, fin);
        chk(sel_row == 0 && sel_score == 2, "R6", "first row", sel_row, 0);
        observe(0);
        expect_outcome("R6", 1'b0, fin);
        chk(done && ambiguous, "R6", "duplicate excluded", {done, ambiguous}, 3);

        // Failed evidence fixes the answer at once (R9)
        begin_session(1'b0, 16'h0000, 16'h0004);
        expect_outcome("R9", 1'b0, fin);
        chk(cand_mask == 16'h0004 && !ambiguous, "R9", "failed evidence", cand_mask, 16'h0004);

        // Every row used, candidates remain (R8 R10)
        clear_table();
        for (int r = 0; r < ROWS; r++) begin
            write_cell(r, 0, 16'(1 << r));
            write_cell(r, 1, ~16'(1 << r));
        end
        begin_session(1'b0, 16'h0000, 16'h0000);
        run_rest("R8", 1'b1);
        chk(done && ambiguous && cand_mask == 16'hFF00, "R10", "rows exhausted",
            cand_mask, 16'hFF00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule